// File: doc/BRIEF.md
# Local Bus Cycle Timeout Monitor

This block watches a processor-style local bus and ends any cycle that no slave answers. When the bus master raises the transfer-start strobe, the monitor starts a per-cycle timer that counts ticks of one microsecond. If neither a normal acknowledge nor an error acknowledge comes back before the selected period runs out, the monitor returns a one-clock transfer-error-acknowledge pulse to the master. The master can then abort the access instead of hanging.

A 2-bit period field picks one of three periods or turns the timer off. The field is written through a write strobe and clears to 0 at reset. A cycle whose destination is the external backplane bus is not timed, because the backplane has its own access timing. The microsecond tick comes from a free-running prescaler set by the `CLK_MHZ` parameter.

The controller is a three-state machine:
- **IDLE** goes to **RUN** on *launch*: a start strobe for a local destination while the period code is not off. The transition latches the period and clears the tick count.
- **RUN** goes back to **IDLE** on *answered*: a normal or error acknowledge.
- **RUN** goes to **FIRE** on *expire*: the last tick of the period arrives with no acknowledge.
- **FIRE** lasts one clock, drives the error pulse and returns to **IDLE** on *done*.

Top module: `cycle_timeout_monitor`

## Requirements
- R1: After reset the period code is 0, so an unanswered local cycle times out after the 8 µs period.
- R2: With code 0, an unanswered local cycle gets its error pulse on clock edge d after the start edge, where (8-1)·CLK_MHZ < d ≤ 8·CLK_MHZ. The start edge is the clock edge that samples the start strobe.
- R3: With code 1, the same window applies with 64 µs in place of 8 µs.
- R4: With code 2, the same window applies with 256 µs in place of 8 µs.
- R5: With code 3 the timer is off, and no error pulse is ever produced.
- R6: A start strobe sampled together with the backplane-destination input high starts no timer and produces no error pulse.
- R7: A normal acknowledge during a timed cycle ends the timing without an error pulse. The next cycle is again timed over its full period.
- R8: An error acknowledge from a slave during a timed cycle likewise ends the timing without an error pulse from the monitor.
- R9: The error pulse lasts exactly one clock and occurs at most once per cycle. No further pulse comes until a new start strobe arrives.
- R10: A period code written while a cycle is being timed does not change that cycle's period. It takes effect from the next start strobe.
- R11: A start strobe that arrives while a cycle is already being timed is ignored, and the running timer is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the period code |
| cfg_period | input | 2 | Period code: 0=8 µs, 1=64 µs, 2=256 µs, 3=off |
| bus_start | input | 1 | Transfer-start strobe, one clock per cycle |
| bus_dest_ext | input | 1 | The current transfer targets the backplane bus (sampled with bus_start) |
| bus_ack | input | 1 | Normal transfer acknowledge |
| bus_err_in | input | 1 | Error acknowledge from a slave |
| bus_tea | output | 1 | Transfer-error-acknowledge pulse to the bus master |

## Verification
The bench measures each timeout in clock edges counted from the start edge and checks it against the window each code allows. A decoder that swapped codes or miscounted ticks by one microsecond would fall outside that window. An acknowledge is injected early, and a fresh full-length cycle follows it, which catches a counter that is stopped but never cleared. Separate tests confirm that backplane and off-code cycles stay silent, and that the error pulse neither repeats nor stretches past one clock. Two further tests apply a mid-cycle code write and a second start strobe; a design that re-latched the period or restarted the count on either would fire at the wrong time.

// File: rtl/cto_pkg.sv
package cto_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIRE = 2'd2
    } cto_state_e;

    localparam int unsigned TICKS_C0  = 8;
    localparam int unsigned TICKS_C1  = 64;
    localparam int unsigned TICKS_C2  = 256;
    localparam int unsigned CNT_W     = $clog2(TICKS_C2 + 1);
    localparam logic [1:0]  CODE_OFF  = 2'd3;

    function automatic logic [CNT_W-1:0] ticks_for(input logic [1:0] code);
        unique case (code)
            2'd0:    return CNT_W'(TICKS_C0);
            2'd1:    return CNT_W'(TICKS_C1);
            default: return CNT_W'(TICKS_C2);
        endcase
    endfunction
endpackage

// File: rtl/cto_us_prescaler.sv
module cto_us_prescaler #(
    parameter int unsigned CLK_MHZ = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (CLK_MHZ <= 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_divide
            localparam int unsigned DIV_W = $clog2(CLK_MHZ);
            localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_MHZ - 1);
            logic [DIV_W-1:0] div_q;
            logic             tick_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    div_q  <= (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
                    tick_q <= (div_q == DIV_TOP);
                end
            end
            assign tick_o = tick_q;

            // R2: ticks are isolated single-clock pulses
            a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate
endmodule

// File: rtl/cto_period_cfg.sv
module cto_period_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [1:0] data_i,
    output logic [1:0] code_o
);
    logic [1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= 2'd0;
        else if (we_i) code_q <= data_i;
    end
    assign code_o = code_q;

    // R1: the code only moves on a write
    a_r1_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(code_q));
endmodule

// File: rtl/cycle_timeout_monitor.sv
module cycle_timeout_monitor #(
    parameter int unsigned CLK_MHZ = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_period,
    input  logic       bus_start,
    input  logic       bus_dest_ext,
    input  logic       bus_ack,
    input  logic       bus_err_in,
    output logic       bus_tea
);
    import cto_pkg::*;

    logic             us_tick;
    logic [1:0]       period_code;
    cto_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, limit_q;
    logic             launch, answered, expire;

    cto_us_prescaler #(.CLK_MHZ(CLK_MHZ)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_o(us_tick)
    );

    cto_period_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we),
        .data_i(cfg_period), .code_o(period_code)
    );

    assign launch   = bus_start && !bus_dest_ext && (period_code != CODE_OFF);
    assign answered = bus_ack || bus_err_in;
    assign expire   = us_tick && (cnt_q == limit_q - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_RUN;
            S_RUN: begin
                if (answered)    state_d = S_IDLE;
                else if (expire) state_d = S_FIRE;
            end
            S_FIRE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // per-cycle tick counter and latched period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= ticks_for(2'd0);
        end else if (state_q == S_IDLE && launch) begin
            cnt_q   <= '0;
            limit_q <= ticks_for(period_code);
        end else if (state_q == S_RUN && us_tick && !answered) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_tea = (state_q == S_FIRE);
    end

    // R9: one-clock pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tea |=> !bus_tea);
    // R7 / R8: any acknowledge ends the timing quietly
    a_r7_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && answered) |=> (state_q == S_IDLE && !bus_tea));
    // R6: backplane cycles are not timed
    a_r6_ext_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && bus_start && bus_dest_ext) |=> state_q == S_IDLE);
    // R5: off code never arms
    a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && period_code == CODE_OFF) |=> state_q == S_IDLE);
    // R10: latched period stays fixed while timing
    a_r10_limit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |=> $stable(limit_q));
    // R11: no restart while running
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && bus_start && !answered) |=>
            (state_q != S_RUN || cnt_q >= $past(cnt_q)));
    // R2: count stays below the latched period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (cnt_q < limit_q));
endmodule

// File: tb/test_cycle_timeout_monitor.sv
module test_cycle_timeout_monitor;
    localparam int unsigned MHZ = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_period = 2'd0;
    logic bus_start = 1'b0, bus_dest_ext = 1'b0, bus_ack = 1'b0, bus_err_in = 1'b0;
    logic bus_tea;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cycle_timeout_monitor #(.CLK_MHZ(MHZ)) i_cycle_timeout_monitor (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_period(cfg_period),
        .bus_start(bus_start), .bus_dest_ext(bus_dest_ext),
        .bus_ack(bus_ack), .bus_err_in(bus_err_in), .bus_tea(bus_tea)
    );

    task automatic check(input string req, input int actual, input int expected_lo,
                         input int expected_hi);
        n_checks++;
        if (actual < expected_lo || actual > expected_hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, actual,
                     expected_lo, expected_hi);
        end
    endtask

    task automatic write_code(input logic [1:0] c);
        @(negedge clk); cfg_we = 1'b1; cfg_period = c;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // start strobe sampled at the next posedge (the start edge)
    task automatic start_cycle(input logic ext);
        @(negedge clk); bus_start = 1'b1; bus_dest_ext = ext;
        @(negedge clk); bus_start = 1'b0; bus_dest_ext = 1'b0;
    endtask

    // edges after the start edge until bus_tea is seen; -1 if none within limit
    task automatic wait_tea(input int limit, output int d);
        d = -1;
        for (int i = 1; i <= limit; i++) begin
            if (bus_tea) begin d = i; break; end
            @(negedge clk);
        end
    endtask

    task automatic pulses_in(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bus_tea) n++;
        end
    endtask

    task automatic timed_window(input string req, input int us);
        int d, w;
        start_cycle(1'b0);
        wait_tea(us * MHZ + 10, d);
        check(req, d, (us - 1) * MHZ + 1, us * MHZ);
        pulses_in(1, w);
        check("R9 width", w, 0, 0);
    endtask

    task automatic t_reset;
        check("R1 tea low in reset", int'(bus_tea), 0, 0);
        timed_window("R1 default 8us", 8);
    endtask

    task automatic t_codes;
        write_code(2'd0); timed_window("R2 code0", 8);
        write_code(2'd1); timed_window("R3 code1", 64);
        write_code(2'd2); timed_window("R4 code2", 256);
    endtask

    task automatic t_off;
        int n;
        write_code(2'd3); start_cycle(1'b0); pulses_in(300 * MHZ, n);
        check("R5 off", n, 0, 0);
    endtask

    task automatic t_ext;
        int n;
        write_code(2'd0); start_cycle(1'b1); pulses_in(20 * MHZ, n);
        check("R6 backplane", n, 0, 0);
    endtask

    task automatic t_ack(input bit use_err);
        int n;
        write_code(2'd0); start_cycle(1'b0);
        repeat (5 * MHZ) @(negedge clk);
        if (use_err) bus_err_in = 1'b1; else bus_ack = 1'b1;
        @(negedge clk); bus_err_in = 1'b0; bus_ack = 1'b0;
        pulses_in(20 * MHZ, n);
        if (use_err) check("R8 slave error ends", n, 0, 0);
        else begin
            check("R7 ack ends", n, 0, 0);
            timed_window("R7 full period after ack", 8);
        end
    endtask

    task automatic t_once;
        int d, n;
        write_code(2'd0); start_cycle(1'b0);
        wait_tea(8 * MHZ + 10, d);
        check("R9 fired", d, 7 * MHZ + 1, 8 * MHZ);
        pulses_in(30 * MHZ, n);
        check("R9 no repeat", n, 0, 0);
    endtask

    task automatic t_midchange;
        int d;
        write_code(2'd0); start_cycle(1'b0);
        write_code(2'd2);
        wait_tea(8 * MHZ + 10, d);
        check("R10 old period kept", d, 7 * MHZ - 1, 8 * MHZ - 2);
        @(negedge clk);
        timed_window("R10 new period next cycle", 256);
    endtask

    task automatic t_restart;
        int d;
        write_code(2'd0); start_cycle(1'b0);
        repeat (5 * MHZ - 1) @(negedge clk);
        start_cycle(1'b0);
        wait_tea(8 * MHZ + 10, d);
        d = d + 5 * MHZ + 1;
        check("R11 no restart", d, 7 * MHZ + 1, 8 * MHZ);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_codes();
        t_off();
        t_ext();
        t_ack(1'b0);
        t_ack(1'b1);
        t_once();
        t_midchange();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule